// File: doc/BRIEF.md
# Multiplexed-Bus Instruction Fetch Sequencer

This block runs the external memory read cycles through which a small 8-bit processor core gets its instruction bytes. Each bus cycle has three states, T1, T2 and T3. Each state lasts two periods of the crystal clock, because the state clock runs at half the crystal rate. The upper address byte has dedicated output lines. The lower address byte shares its lines with the returning data byte: it is driven while the address strobe is low, and the lines are released before the data strobe falls. The byte read at the end of T3 is handed to the instruction decoder through a valid/ready stream, with a flag that marks opcode bytes.

While the current instruction executes, the unit fetches the opcode of the next one in an overlapped cycle. When the decoder accepts an opcode it also supplies the instruction length. The unit then fetches one or two operand bytes from the following addresses before the next opcode. Execution can flush the unit with a new program counter, which throws away any prefetched or in-flight byte. Execution can also request a data read, which takes the bus at the next cycle boundary. A prefetched byte that is still held at that point is dropped and later fetched again from the same address, so the accepted byte stream never has a gap.

Back-pressure rules for the byte stream: a byte appears on `ib_data` with `ib_valid` high and stays unchanged until a clock edge at which `ib_ready` is high. While a byte is held, no new fetch cycle starts. The unit waits in the first half of T1 with both strobes high. `op_len` is sampled only at the edge that accepts an opcode byte. A handshake in the same clock as `flush_req` does not count as delivery. The data-request port is also valid/ready: `dreq_ready` is high only in the first half of T1. The response is a single-clock pulse with no back-pressure.

Top module: `mbus_fetch_unit`

## Requirements
- R1: A bus cycle is T1, T2, T3 with two crystal clocks per state, followed directly by the next T1. The only exception is that T1's first half repeats while the unit is stalled. `as_n` is low only in the second half of T1, for exactly one clock. `ds_n` is low from the second half of T2 to the end of T3, for exactly three clocks.
- R2: `adr_hi` carries address bits 15..8 and stays stable from the second half of T1 to the end of T3. `ad_out` carries bits 7..0 with `ad_oe` high whenever `as_n` is low. `ad_oe` is low in the clock before `ds_n` falls. `rd_wr_n` is high (read) during every data strobe.
- R3: `port_strobe` is a one-clock pulse in the first half of T2, which is the clock right after `as_n` was low.
- R4: The byte on `ad_in` is captured at the last edge of T3 and appears on `ib_data` with `ib_valid` from the next clock.
- R5: A byte that has not been accepted keeps `ib_valid`, `ib_data` and `ib_opc` unchanged. No new fetch cycle starts while it is held (`as_n` stays high unless a data read takes the bus).
- R6: Accepted bytes come from consecutive addresses, starting at address 0 after reset and wrapping at 16 bits.
- R7: `ib_opc`=1 marks an opcode byte. `op_len` is sampled when an opcode is accepted. A value of 0 or 1 means no operand bytes follow, 2 means one, and 3 means two. Operand bytes carry `ib_opc`=0, and the next opcode follows them.
- R8: A one-clock `flush_req` discards the held byte and any fetch cycle in flight. The next byte delivered is an opcode read from `flush_pc`.
- R9: A data read is granted at `dreq_valid && dreq_ready`, and a grant takes priority over a fetch. The read runs one bus cycle at `dreq_addr`. One clock after that cycle's T3 ends, `dresp_valid` pulses for one clock with the byte read.
- R10: A data read that is granted while a prefetched byte is held, and not accepted in that clock, discards the byte. The byte is later fetched again from the same address, so the accepted stream stays consecutive.
- R11: During reset `as_n` and `ds_n` are high, while `ad_oe`, `ib_valid` and `dresp_valid` are low. The first cycle after reset fetches an opcode from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adr_hi | output | 8 | Dedicated upper address lines |
| ad_out | output | 8 | Lower address onto shared lines |
| ad_oe | output | 1 | Drive enable for shared lines |
| ad_in | input | 8 | Byte read from shared lines |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rd_wr_n | output | 1 | High for read cycles |
| port_strobe | output | 1 | Port input sampling pulse in T2 |
| ib_valid | output | 1 | Instruction byte valid |
| ib_ready | input | 1 | Decoder accepts byte |
| ib_data | output | 8 | Instruction byte |
| ib_opc | output | 1 | Byte is an opcode |
| op_len | input | 2 | Instruction length, sampled on opcode accept |
| flush_req | input | 1 | Discard prefetch and restart |
| flush_pc | input | 16 | Restart address |
| dreq_valid | input | 1 | Data read request |
| dreq_ready | output | 1 | Data read can be granted |
| dreq_addr | input | 16 | Data read address |
| dresp_valid | output | 1 | Data read result pulse |
| dresp_data | output | 8 | Data read result |

## Verification
The embedded properties check the local timing on every clock: the order of the states, the single-clock address strobe, the bus release before the data strobe, the stable upper address, the position of the port pulse, the held output byte, the absence of a new cycle while a byte is held, and the single-clock response pulse. Only the bench scenarios can show that bytes come from the right addresses in the right order. That covers operand counting from the sampled length, the restart at the flush address including the wrap at the top of the address space, and the refetch of a byte dropped by a data read, which together keep the accepted stream consecutive.

// File: rtl/mbf_pkg.sv
`timescale 1ns/1ps
package mbf_pkg;
  // Half-states of one bus cycle; "A" is the first crystal clock, "B" the second.
  typedef enum logic [2:0] {
    TS_T1A = 3'd0,
    TS_T1B = 3'd1,
    TS_T2A = 3'd2,
    TS_T2B = 3'd3,
    TS_T3A = 3'd4,
    TS_T3B = 3'd5
  } tstate_e;
endpackage

// File: rtl/mbf_tseq.sv
`timescale 1ns/1ps
module mbf_tseq
  import mbf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  output tstate_e st,
  output logic    as_n,
  output logic    ds_n,
  output logic    addr_drive,
  output logic    port_strobe,
  output logic    at_t1a,
  output logic    at_last
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TS_T1A;
    end else begin
      case (st)
        TS_T1A:  if (go) st <= TS_T1B;
        TS_T3B:  st <= TS_T1A;
        default: st <= tstate_e'(st + 3'd1);
      endcase
    end
  end

  always_comb begin
    as_n        = (st != TS_T1B);
    ds_n        = !(st inside {TS_T2B, TS_T3A, TS_T3B});
    addr_drive  = (st == TS_T1B);
    port_strobe = (st == TS_T2A);
    at_t1a      = (st == TS_T1A);
    at_last     = (st == TS_T3B);
  end

  AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st != TS_T1A) |-> (st == tstate_e'($past(st) + 3'd1))); // R1
  AST_T1_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == TS_T3B) |-> (st == TS_T1A)); // R1

endmodule

// File: rtl/mbf_ctl.sv
`timescale 1ns/1ps
module mbf_ctl #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_t1a,
  input  logic              at_last,
  input  logic              flush_req,
  input  logic [ADDR_W-1:0] flush_pc,
  input  logic              dreq_valid,
  input  logic [ADDR_W-1:0] dreq_addr,
  input  logic              accept,
  input  logic              buf_valid,
  input  logic              buf_opc,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [LEN_W-1:0]  op_len,
  output logic              go,
  output logic              dreq_ready,
  output logic              kill_buf,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_data,
  output logic              cyc_opc,
  output logic              drop
);

  localparam logic [LEN_W-1:0] OPS_MAX = LEN_W'((1 << LEN_W) - 2);

  logic [ADDR_W-1:0] pc, pc_eff;
  logic [LEN_W-1:0]  ops_left, ops_base, len_ops;
  logic              discard, dgrant, fgo, buf_free;

  always_comb begin
    len_ops    = (op_len == '0) ? '0 : op_len - LEN_W'(1);
    pc_eff     = flush_req ? flush_pc : pc;
    ops_base   = flush_req ? '0 : ((accept && buf_opc) ? len_ops : ops_left);
    dreq_ready = at_t1a;
    dgrant     = at_t1a && dreq_valid;
    buf_free   = !buf_valid || accept || flush_req;
    fgo        = at_t1a && !dreq_valid && buf_free;
    go         = dgrant || fgo;
    kill_buf   = dgrant && buf_valid && !accept && !flush_req;
    drop       = discard || flush_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= RESET_PC;
      ops_left <= '0;
      cyc_addr <= RESET_PC;
      cyc_data <= 1'b0;
      cyc_opc  <= 1'b1;
      discard  <= 1'b0;
    end else begin
      if (flush_req) begin
        pc       <= flush_pc;
        ops_left <= '0;
      end
      if (dgrant) begin
        cyc_addr <= dreq_addr;
        cyc_data <= 1'b1;
        pc       <= kill_buf ? buf_addr : pc_eff;
        ops_left <= (kill_buf && !buf_opc) ? ops_base + LEN_W'(1) : ops_base;
      end else if (fgo) begin
        cyc_addr <= pc_eff;
        cyc_data <= 1'b0;
        cyc_opc  <= (ops_base == '0);
        pc       <= pc_eff + ADDR_W'(1);
        ops_left <= (ops_base == '0) ? '0 : ops_base - LEN_W'(1);
      end
      if (at_last)
        discard <= 1'b0;
      else if (flush_req && !at_t1a)
        discard <= 1'b1;
    end
  end

  AST_OPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ops_left <= OPS_MAX); // R7
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (at_t1a && dreq_valid) |=> cyc_data); // R9

endmodule

// File: rtl/mbf_obuf.sv
`timescale 1ns/1ps
module mbf_obuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_is_data,
  input  logic              cap_drop,
  input  logic              cap_opc,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              clr,
  input  logic              flush_req,
  input  logic              ib_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_opc,
  output logic [ADDR_W-1:0] out_addr,
  output logic              accept,
  output logic              dresp_valid,
  output logic [DATA_W-1:0] dresp_data
);

  assign accept = out_valid && ib_ready && !flush_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_opc     <= 1'b0;
      out_addr    <= '0;
      dresp_valid <= 1'b0;
      dresp_data  <= '0;
    end else begin
      if (cap && !cap_is_data && !cap_drop) begin
        out_valid <= 1'b1;
        out_data  <= cap_data;
        out_opc   <= cap_opc;
        out_addr  <= cap_addr;
      end else if (clr || accept) begin
        out_valid <= 1'b0;
      end
      dresp_valid <= cap && cap_is_data;
      if (cap && cap_is_data) dresp_data <= cap_data;
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_valid && !ib_ready && !clr) |->
      (out_valid && $stable(out_data) && $stable(out_opc))); // R5
  AST_DRESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dresp_valid |=> !dresp_valid); // R9

endmodule

// File: rtl/mbus_fetch_unit.sv
`timescale 1ns/1ps
module mbus_fetch_unit
  import mbf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [ADDR_W-DATA_W-1:0] adr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     as_n,
  output logic                     ds_n,
  output logic                     rd_wr_n,
  output logic                     port_strobe,
  output logic                     ib_valid,
  input  logic                     ib_ready,
  output logic [DATA_W-1:0]        ib_data,
  output logic                     ib_opc,
  input  logic [LEN_W-1:0]         op_len,
  input  logic                     flush_req,
  input  logic [ADDR_W-1:0]        flush_pc,
  input  logic                     dreq_valid,
  output logic                     dreq_ready,
  input  logic [ADDR_W-1:0]        dreq_addr,
  output logic                     dresp_valid,
  output logic [DATA_W-1:0]        dresp_data
);

  localparam int HI_W = ADDR_W - DATA_W;

  tstate_e           st;
  logic              go, addr_drive, at_t1a, at_last;
  logic              kill_buf, cyc_data, cyc_opc, drop, accept;
  logic [ADDR_W-1:0] cyc_addr, buf_addr;

  mbf_tseq u_tseq (
    .clk(clk), .rst_n(rst_n), .go(go), .st(st),
    .as_n(as_n), .ds_n(ds_n), .addr_drive(addr_drive),
    .port_strobe(port_strobe), .at_t1a(at_t1a), .at_last(at_last)
  );

  mbf_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_PC(RESET_PC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .at_t1a(at_t1a), .at_last(at_last),
    .flush_req(flush_req), .flush_pc(flush_pc),
    .dreq_valid(dreq_valid), .dreq_addr(dreq_addr),
    .accept(accept), .buf_valid(ib_valid), .buf_opc(ib_opc), .buf_addr(buf_addr),
    .op_len(op_len), .go(go), .dreq_ready(dreq_ready), .kill_buf(kill_buf),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_opc(cyc_opc), .drop(drop)
  );

  mbf_obuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_obuf (
    .clk(clk), .rst_n(rst_n), .cap(at_last), .cap_data(ad_in),
    .cap_is_data(cyc_data), .cap_drop(drop), .cap_opc(cyc_opc), .cap_addr(cyc_addr),
    .clr(flush_req || kill_buf), .flush_req(flush_req), .ib_ready(ib_ready),
    .out_valid(ib_valid), .out_data(ib_data), .out_opc(ib_opc), .out_addr(buf_addr),
    .accept(accept), .dresp_valid(dresp_valid), .dresp_data(dresp_data)
  );

  assign adr_hi  = cyc_addr[ADDR_W-1 -: HI_W];
  assign ad_out  = addr_drive ? cyc_addr[DATA_W-1:0] : '0;
  assign ad_oe   = addr_drive;
  assign rd_wr_n = 1'b1;

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {TS_T2A, TS_T2B, TS_T3A, TS_T3B}) |-> $stable(adr_hi)); // R2
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> !$past(ad_oe)); // R2
  AST_ADDR_WITH_AS: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> ad_oe); // R2
  AST_PORT_IN_T2: assert property (@(posedge clk) disable iff (!rst_n)
    port_strobe |-> !$past(as_n)); // R3
  AST_NO_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && !ib_ready && !flush_req && !dreq_valid) |=> as_n); // R5

endmodule

// File: tb/mbus_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module mbus_fetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  adr_hi, ad_out, ad_in, ib_data, dresp_data;
  logic        ad_oe, as_n, ds_n, rd_wr_n, port_strobe;
  logic        ib_valid, ib_opc, dreq_ready, dresp_valid;
  logic        ib_ready = 1'b0, flush_req = 1'b0, dreq_valid = 1'b0;
  logic [1:0]  op_len = 2'd0;
  logic [15:0] flush_pc = '0, dreq_addr = '0, lat_addr = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbus_fetch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .adr_hi(adr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .as_n(as_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n),
    .port_strobe(port_strobe), .ib_valid(ib_valid), .ib_ready(ib_ready),
    .ib_data(ib_data), .ib_opc(ib_opc), .op_len(op_len), .flush_req(flush_req),
    .flush_pc(flush_pc), .dreq_valid(dreq_valid), .dreq_ready(dreq_ready),
    .dreq_addr(dreq_addr), .dresp_valid(dresp_valid), .dresp_data(dresp_data)
  );

  function automatic logic [7:0] memval(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  // Memory model: latch the address while the address strobe is low.
  always @(posedge clk) if (!as_n) lat_addr <= {adr_hi, ad_out};
  assign ad_in = memval(lat_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [15:0] exp_pc;
  bit          exp_opc, granted, d_pend, after_flush, after_data;
  int          ops_left, ds_run, as_run;
  logic [15:0] d_addr;
  bit          p_as_n, p_ds_n, p_oe, p_valid, p_ready, p_clr;
  logic [7:0]  p_data;
  bit          p_opc;

  always @(negedge clk) begin
    #5;
    if (!rst_n) begin
      exp_pc = 16'h0000; exp_opc = 1; ops_left = 0; granted = 0; d_pend = 0;
      after_flush = 0; after_data = 0; ds_run = 0; as_run = 0;
      p_as_n = 1; p_ds_n = 1; p_oe = 0; p_valid = 0; p_ready = 0; p_clr = 0;
      p_data = '0; p_opc = 0;
    end else begin
      // R1 strobe widths
      if (!ds_n) ds_run++;
      else begin
        if (ds_run != 0) check(ds_run == 3, "R1", ds_run, 3);
        ds_run = 0;
      end
      if (!as_n) begin
        as_run++;
        check(ad_oe, "R2", ad_oe, 1);
      end else begin
        if (as_run != 0) check(as_run == 1, "R1", as_run, 1);
        as_run = 0;
      end
      if (!ds_n && p_ds_n) check(!p_oe && !ad_oe, "R2", p_oe, 0);
      if (!ds_n) check(rd_wr_n, "R2", rd_wr_n, 1);
      if (port_strobe) check(!p_as_n, "R3", p_as_n, 0);
      // R4 byte appears one clock after the data strobe ends
      if (ib_valid && !p_valid) check(!p_ds_n, "R4", p_ds_n, 0);
      // R5 hold and no new cycle while held
      if (p_valid && !p_ready && !p_clr)
        check(ib_valid && ib_data == p_data && ib_opc == p_opc, "R5", {ib_valid, ib_data}, {1'b1, p_data});
      if (ib_valid && !as_n) check(d_pend, "R5", 0, 1);
      // R9 response
      if (dresp_valid) begin
        check(d_pend, "R9", 0, 1);
        check(dresp_data == memval(d_addr), "R9", dresp_data, memval(d_addr));
        d_pend = 0; after_data = 1;
      end
      // Decoder model
      if (ib_valid && ib_ready && !flush_req) begin
        check(ib_data == memval(exp_pc), after_flush ? "R8" : (after_data ? "R10" : "R6"),
              ib_data, memval(exp_pc));
        check(ib_opc == exp_opc, after_flush ? "R8" : "R7", ib_opc, exp_opc);
        after_flush = 0; after_data = 0;
        if (exp_opc) begin
          op_len = 2'($urandom_range(0, 3));
          ops_left = (op_len == 0) ? 0 : int'(op_len) - 1;
        end else begin
          ops_left--;
        end
        exp_opc = (ops_left == 0);
        exp_pc = exp_pc + 16'd1;
      end
      if (flush_req) begin
        exp_pc = flush_pc; exp_opc = 1; ops_left = 0; after_flush = 1;
      end
      p_clr = flush_req;
      if (dreq_valid && dreq_ready) begin
        granted = 1; d_pend = 1; d_addr = dreq_addr; p_clr = 1;
      end
      p_as_n = as_n; p_ds_n = ds_n; p_oe = ad_oe;
      p_valid = ib_valid; p_ready = ib_ready; p_data = ib_data; p_opc = ib_opc;
    end
  end

  task automatic step(input bit rdy, input bit fl, input logic [15:0] fpc,
                      input bit dq, input logic [15:0] dqa);
    @(negedge clk);
    if (dreq_valid && granted) begin dreq_valid = 0; granted = 0; end
    flush_req = fl;
    flush_pc  = fpc;
    ib_ready  = fl ? 1'b0 : rdy;
    if (dq && !dreq_valid && !d_pend) begin dreq_valid = 1; dreq_addr = dqa; end
  endtask

  initial begin
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    #5;
    // R11 reset state
    check(as_n == 1, "R11", as_n, 1);
    check(ds_n == 1, "R11", ds_n, 1);
    check(ad_oe == 0, "R11", ad_oe, 0);
    check(ib_valid == 0, "R11", ib_valid, 0);
    check(dresp_valid == 0, "R11", dresp_valid, 0);
    @(negedge clk) rst_n = 1;
    // Streaming with the decoder always ready
    repeat (150) step(1, 0, '0, 0, '0);
    // Long stall
    repeat (40) step(0, 0, '0, 0, '0);
    repeat (30) step(1, 0, '0, 0, '0);
    // Flush while stalled, and a flush near the top of the address space
    repeat (12) step(0, 0, '0, 0, '0);
    step(0, 1, 16'h8000, 0, '0);
    repeat (40) step(1, 0, '0, 0, '0);
    step(1, 1, 16'hFFFE, 0, '0);
    repeat (40) step(1, 0, '0, 0, '0);
    // Data read while a prefetched byte is held
    repeat (10) step(0, 0, '0, 0, '0);
    step(0, 0, '0, 1, 16'h1234);
    repeat (30) step(0, 0, '0, 0, '0);
    repeat (40) step(1, 0, '0, 0, '0);
    // Random mix
    for (int i = 0; i < 5000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 49) == 0, 16'($urandom),
           $urandom_range(0, 39) == 0, 16'($urandom));
    repeat (20) step(1, 0, '0, 0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule